// File: doc/BRIEF.md
# Wake and Interrupt Register Controller

This block keeps two 16-bit control words for a supply-and-wake supervisor. One is an interrupt-enable word and the other is an interrupt-status word. Both are reached through a simple register port: a 3-bit address, a write strobe and write data, with read data returned combinationally for the selected address. The upper three bits of each word always read back the word's own address. Bit 12 of each word is a lock that freezes the rest of that word.

Event sources enter as single-cycle strobes: primary and secondary supply undervoltage warnings, a cyclic timer tick and a bus wake indication. Two asynchronous wake pins are also accepted. Each wake pin is synchronised and edge-detected according to a 2-bit edge selector. Qualified events set sticky pending flags, and software clears a flag by writing a one to its position. The interrupt output stays high while any flag is pending. A power-on flag is already pending when reset ends, so the first interrupt is raised without any event.

Top module: `wkirq_regctl`

## Requirements
- R1: After reset the enable word (address 3'b010) reads 16'h4000, the status word (address 3'b011) reads 16'h6020 with the power-on flag at bit 5 set, irq is 1 and xcvr_lowpwr is 0.
- R2: Bits 15:13 always read the word's own address, and writes cannot change them. Any other address reads 16'h0000, and writes to it change nothing.
- R3: Bit 12 of each word is a lock. While it is 1, a write to that word updates only bit 12; all other stored bits, including pending status flags, keep their values. Writing 0 to bit 12 releases the lock.
- R4: A uv_pri_evt strobe sets status bit 11 only when enable bit 11 is 1. A uv_sec_evt strobe sets status bit 10 only when enable bit 10 is 1.
- R5: Enable bits 7:6 select edges for wake_pin[0] and set status bit 6. Enable bits 5:4 select edges for wake_pin[1] and set status bit 4. The encoding is 00 none, 01 rising, 10 falling, 11 both. The flag is set on the third rising clock edge after the pin change is first sampled.
- R6: A bus_wake strobe sets status bit 3 only when enable bit 3 is 1, and xcvr_lowpwr follows enable bit 3.
- R7: A cyc_tick strobe always sets status bit 7 on the next clock edge.
- R8: Writing 1 to a status flag position (11, 10, 7, 6, 5, 4 or 3) clears that flag, and writing 0 leaves it unchanged. Bits 9:8 and 2:0 of both words read 0. Enable bits 3, 7:4 and 11:10 are plain read/write.
- R9: If an event and a clearing write reach the same flag in the same cycle, the flag remains set.
- R10: irq is 1 exactly while at least one status flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 3 | Register address (3'b010 enable, 3'b011 status) |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| uv_pri_evt | input | 1 | Primary supply undervoltage warning strobe |
| uv_sec_evt | input | 1 | Secondary supply undervoltage warning strobe |
| cyc_tick | input | 1 | Cyclic timer tick strobe |
| bus_wake | input | 1 | Bus wake detection strobe |
| wake_pin | input | 2 | Asynchronous wake pins |
| xcvr_lowpwr | output | 1 | Bus transceiver low-power wake-detect request |
| irq | output | 1 | Interrupt request, high while any flag is pending |

## Verification
Register writes, the lock and the strobe inputs all act on the next rising edge. Read data and irq follow with no further delay. A wake pin change needs two synchroniser edges plus one edge-register edge, so its flag is due on the third edge after the pin is first sampled. The bench drives inputs shortly after each falling edge. A behavioural model steps at every rising edge with the same inputs, keeping the wake pin history in a queue. Outputs are compared with the model at every falling edge, so each result is checked in exactly the cycle it is due, and directed reads confirm fixed expected values.

// File: rtl/wkirq_pkg.sv
package wkirq_pkg;

   localparam int WORD_W    = 16;
   localparam int ADDR_LSB  = 13;
   localparam int FIELD_W   = ADDR_LSB;

   localparam int LOCK_BIT  = 12;
   localparam int UV_PRI    = 11;
   localparam int UV_SEC    = 10;
   localparam int W0_SEL_LSB = 6;
   localparam int W1_SEL_LSB = 4;
   localparam int BUS_BIT   = 3;

   localparam int ST_CYC    = 7;
   localparam int ST_WAKE0  = 6;
   localparam int ST_POR    = 5;
   localparam int ST_WAKE1  = 4;
   localparam int ST_BUS    = 3;

   localparam logic [FIELD_W-1:0] EN_WR_MASK = 13'h1CF8;
   localparam logic [FIELD_W-1:0] ST_FLAGS   = 13'h0CF8;
   localparam logic [FIELD_W-1:0] LOCK_MASK  = 13'h1000;
   localparam logic [FIELD_W-1:0] ST_RESET   = 13'h0020;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } wake_edge_e;

endpackage

// File: rtl/wkirq_wake_edge.sv
module wkirq_wake_edge
   import wkirq_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  wake_edge_e mode_i,
   output logic       hit_o
);

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              rise, fall;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wkirq_wake_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;
   assign fall = ~sync_q[STAGES-1] & prev_q;

   always_comb begin
      unique case (mode_i)
         EDGE_RISE: hit_o = rise;
         EDGE_FALL: hit_o = fall;
         EDGE_BOTH: hit_o = rise | fall;
         default:   hit_o = 1'b0;
      endcase
   end

   // R5: a disabled selector never produces a wake hit
   assert_wake_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == EDGE_OFF) |-> !hit_o);

   // R5: a rising-only selector fires only when the synchronised level is high
   assert_wake_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && mode_i == EDGE_RISE) |=> prev_q);

endmodule

// File: rtl/wkirq_ctrl_reg.sv
module wkirq_ctrl_reg
   import wkirq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [FIELD_W-1:0] wdata_i,
   output logic [FIELD_W-1:0] val_o
);

   logic [FIELD_W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= '0;
      end else if (wr_i) begin
         if (val_q[LOCK_BIT])
            val_q[LOCK_BIT] <= wdata_i[LOCK_BIT];
         else
            val_q <= wdata_i & EN_WR_MASK;
      end
   end

   assign val_o = val_q;

   // R3: a locked word keeps every field except the lock across a write
   assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && val_q[LOCK_BIT]) |=> ((val_q & ~LOCK_MASK) == $past(val_q & ~LOCK_MASK)));

   // R8: reserved positions never hold a one
   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ((val_q & ~EN_WR_MASK) == '0));

endmodule

// File: rtl/wkirq_stat_reg.sv
module wkirq_stat_reg
   import wkirq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] set_i,
   input  logic               wr_i,
   input  logic [FIELD_W-1:0] wdata_i,
   output logic [FIELD_W-1:0] val_o
);

   logic [FIELD_W-1:0] val_q;
   logic [FIELD_W-1:0] clr_mask;
   logic [FIELD_W-1:0] val_d;

   always_comb begin
      clr_mask = '0;
      if (wr_i && !val_q[LOCK_BIT])
         clr_mask = wdata_i & ST_FLAGS;
      val_d = (val_q & ~clr_mask) | (set_i & ST_FLAGS);
      if (wr_i)
         val_d[LOCK_BIT] = wdata_i[LOCK_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         val_q <= ST_RESET;
      else
         val_q <= val_d;
   end

   assign val_o = val_q;

   generate
      for (genvar k = 0; k < FIELD_W; k++) begin : g_flag_chk
         if (ST_FLAGS[k]) begin : g_is_flag
            // R9: an event always lands, even against a clearing write
            assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
               set_i[k] |=> val_q[k]);
            // R8: an unlocked write of one with no event clears the flag
            assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_i && !val_q[LOCK_BIT] && wdata_i[k] && !set_i[k]) |=> !val_q[k]);
            // R3: a locked word never loses a pending flag
            assert_lock_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
               (val_q[LOCK_BIT] && val_q[k]) |=> val_q[k]);
         end
      end
   endgenerate

endmodule

// File: rtl/wkirq_regctl.sv
module wkirq_regctl
   import wkirq_pkg::*;
#(
   parameter int              DATA_W      = 16,
   parameter int              ADDR_W      = 3,
   parameter logic [ADDR_W-1:0] EN_ADDR   = 3'b010,
   parameter logic [ADDR_W-1:0] ST_ADDR   = 3'b011,
   parameter int              SYNC_STAGES = 2,
   parameter int              NUM_WAKE    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              uv_pri_evt,
   input  logic              uv_sec_evt,
   input  logic              cyc_tick,
   input  logic              bus_wake,
   input  logic [NUM_WAKE-1:0] wake_pin,
   output logic              xcvr_lowpwr,
   output logic              irq
);

   localparam int TAG_W = DATA_W - FIELD_W;

   generate
      if (DATA_W != WORD_W) begin : g_bad_width
         $error("wkirq_regctl: DATA_W must equal 16");
      end
      if (TAG_W != ADDR_W) begin : g_bad_addr
         $error("wkirq_regctl: ADDR_W must fill bits above the fields");
      end
      if (NUM_WAKE != 2) begin : g_bad_wake
         $error("wkirq_regctl: the status layout holds two wake flags");
      end
      if (EN_ADDR == ST_ADDR) begin : g_bad_map
         $error("wkirq_regctl: the two words need distinct addresses");
      end
   endgenerate

   logic               en_wr, st_wr;
   logic [FIELD_W-1:0] en_val, st_val;
   logic [FIELD_W-1:0] set_vec;
   logic [NUM_WAKE-1:0] wake_hit;
   logic               unused_tag_bits;

   assign en_wr = reg_wr && (reg_addr == EN_ADDR);
   assign st_wr = reg_wr && (reg_addr == ST_ADDR);
   assign unused_tag_bits = ^reg_wdata[DATA_W-1:FIELD_W];

   wkirq_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (en_wr),
      .wdata_i (reg_wdata[FIELD_W-1:0]),
      .val_o   (en_val)
   );

   generate
      for (genvar w = 0; w < NUM_WAKE; w++) begin : g_wake
         localparam int SEL_LSB = W0_SEL_LSB - 2 * w;
         wkirq_wake_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (wake_pin[w]),
            .mode_i (wake_edge_e'(en_val[SEL_LSB +: 2])),
            .hit_o  (wake_hit[w])
         );
      end
   endgenerate

   always_comb begin
      set_vec           = '0;
      set_vec[UV_PRI]   = uv_pri_evt & en_val[UV_PRI];
      set_vec[UV_SEC]   = uv_sec_evt & en_val[UV_SEC];
      set_vec[ST_CYC]   = cyc_tick;
      set_vec[ST_WAKE0] = wake_hit[0];
      set_vec[ST_WAKE1] = wake_hit[1];
      set_vec[ST_BUS]   = bus_wake & en_val[BUS_BIT];
   end

   wkirq_stat_reg u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_vec),
      .wr_i    (st_wr),
      .wdata_i (reg_wdata[FIELD_W-1:0]),
      .val_o   (st_val)
   );

   always_comb begin
      if (reg_addr == EN_ADDR)
         reg_rdata = {EN_ADDR, en_val};
      else if (reg_addr == ST_ADDR)
         reg_rdata = {ST_ADDR, st_val};
      else
         reg_rdata = '0;
   end

   assign xcvr_lowpwr = en_val[BUS_BIT];
   assign irq         = |(st_val & ST_FLAGS);

   // R4: the primary undervoltage flag only rises after an enabled strobe
   assert_uv_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_val[UV_PRI]) |-> $past(uv_pri_evt && en_val[UV_PRI]));

   // R6: the bus wake flag only rises while low-power detection is requested
   assert_bus_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_val[ST_BUS]) |-> $past(bus_wake && xcvr_lowpwr));

   // R7: a tick is latched on the next edge
   assert_cyc_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_tick |=> irq);

   // R2: the status word always reports its own address
   assert_addr_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ST_ADDR) |-> (reg_rdata[DATA_W-1:FIELD_W] == ST_ADDR));

endmodule

// File: tb/wkirq_regctl_tb.sv
module wkirq_regctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = 3'b000;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        uv_pri_evt = 1'b0, uv_sec_evt = 1'b0, cyc_tick = 1'b0, bus_wake = 1'b0;
   logic [1:0]  wake_pin = 2'b00;
   logic        xcvr_lowpwr, irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit model_on = 1'b0;
   string cur_req = "R1";

   logic [15:0] m_en, m_st;
   logic [1:0]  hist[$];

   always #10 clk = ~clk;

   wkirq_regctl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .uv_pri_evt(uv_pri_evt),
      .uv_sec_evt(uv_sec_evt), .cyc_tick(cyc_tick), .bus_wake(bus_wake),
      .wake_pin(wake_pin), .xcvr_lowpwr(xcvr_lowpwr), .irq(irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, stepped on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 16'h0000;
         m_st = 16'h0020;
         hist = '{2'b00, 2'b00, 2'b00};
      end else begin
         logic [15:0] ev;
         ev = 16'h0;
         if (uv_pri_evt && m_en[11]) ev[11] = 1'b1;
         if (uv_sec_evt && m_en[10]) ev[10] = 1'b1;
         if (cyc_tick) ev[7] = 1'b1;
         if (bus_wake && m_en[3]) ev[3] = 1'b1;
         for (int w = 0; w < 2; w++) begin
            bit older, newer, r, f, hit;
            int sel;
            older = hist[2][w];
            newer = hist[1][w];
            sel   = (m_en >> (6 - 2 * w)) & 3;
            r = newer && !older;
            f = !newer && older;
            hit = (sel == 1 && r) || (sel == 2 && f) || (sel == 3 && (r || f));
            if (hit) ev[(w == 0) ? 6 : 4] = 1'b1;
         end
         if (reg_wr && reg_addr == 3'b010) begin
            if (m_en[12]) m_en[12] = reg_wdata[12];
            else          m_en = reg_wdata & 16'h1CF8;
         end
         if (reg_wr && reg_addr == 3'b011) begin
            if (!m_st[12]) m_st = m_st & ~(reg_wdata & 16'h0CF8);
            m_st[12] = reg_wdata[12];
         end
         m_st = m_st | ev;
         hist.push_front(wake_pin);
         void'(hist.pop_back());
      end
   end

   // compare against the model on every falling edge
   always @(negedge clk) begin
      if (model_on) begin
         logic [15:0] exp_rd;
         if (reg_addr == 3'b010)      exp_rd = 16'h4000 | m_en;
         else if (reg_addr == 3'b011) exp_rd = 16'h6000 | m_st;
         else                         exp_rd = 16'h0000;
         chk(cur_req, reg_rdata, exp_rd);
         chk("R10", {15'h0, irq}, {15'h0, |(m_st & 16'h0CF8)});
         chk("R6", {15'h0, xcvr_lowpwr}, {15'h0, m_en[3]});
      end
   end

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); #2;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); #2;
      reg_wr = 1'b0; reg_wdata = 16'h0;
   endtask

   task automatic rd_expect(input logic [2:0] a, input logic [15:0] exp, input string req);
      @(negedge clk); #2;
      reg_addr = a;
      @(negedge clk);
      chk(req, reg_rdata, exp);
   endtask

   task automatic pulse(input int which);
      @(negedge clk); #2;
      case (which)
         0: uv_pri_evt = 1'b1;
         1: uv_sec_evt = 1'b1;
         2: cyc_tick = 1'b1;
         default: bus_wake = 1'b1;
      endcase
      @(negedge clk); #2;
      uv_pri_evt = 1'b0; uv_sec_evt = 1'b0; cyc_tick = 1'b0; bus_wake = 1'b0;
   endtask

   task automatic set_pin(input int w, input logic v);
      @(negedge clk); #2;
      wake_pin[w] = v;
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2 rst_n = 1'b1;
      model_on = 1'b1;

      // R1 reset values
      cur_req = "R1";
      rd_expect(3'b010, 16'h4000, "R1");
      rd_expect(3'b011, 16'h6020, "R1");
      chk("R1", {15'h0, irq}, 16'h0001);
      chk("R1", {15'h0, xcvr_lowpwr}, 16'h0000);

      // R8 write-one-to-clear
      cur_req = "R8";
      wr(3'b011, 16'h0000);
      rd_expect(3'b011, 16'h6020, "R8");
      wr(3'b011, 16'h0020);
      rd_expect(3'b011, 16'h6000, "R8");
      chk("R10", {15'h0, irq}, 16'h0000);

      // R4 undervoltage gating
      cur_req = "R4";
      pulse(0);
      rd_expect(3'b011, 16'h6000, "R4");
      wr(3'b010, 16'h0800);
      reg_addr = 3'b011;
      pulse(0);
      pulse(1);
      rd_expect(3'b011, 16'h6800, "R4");
      chk("R10", {15'h0, irq}, 16'h0001);
      wr(3'b010, 16'h0C00);
      pulse(1);
      rd_expect(3'b011, 16'h6C00, "R4");
      wr(3'b011, 16'h0C00);
      rd_expect(3'b011, 16'h6000, "R8");

      // R5 wake edge selection
      cur_req = "R5";
      wr(3'b010, 16'h0040);
      reg_addr = 3'b011;
      set_pin(0, 1'b1);
      rd_expect(3'b011, 16'h6040, "R5");
      wr(3'b011, 16'h0040);
      set_pin(0, 1'b0);
      rd_expect(3'b011, 16'h6000, "R5");
      wr(3'b010, 16'h0080);
      set_pin(0, 1'b1);
      rd_expect(3'b011, 16'h6000, "R5");
      set_pin(0, 1'b0);
      rd_expect(3'b011, 16'h6040, "R5");
      wr(3'b011, 16'h0040);
      wr(3'b010, 16'h00C0);
      set_pin(0, 1'b1);
      rd_expect(3'b011, 16'h6040, "R5");
      wr(3'b011, 16'h0040);
      set_pin(0, 1'b0);
      rd_expect(3'b011, 16'h6040, "R5");
      wr(3'b011, 16'h0040);
      wr(3'b010, 16'h0000);
      set_pin(0, 1'b1);
      set_pin(0, 1'b0);
      rd_expect(3'b011, 16'h6000, "R5");
      wr(3'b010, 16'h0010);
      set_pin(1, 1'b1);
      rd_expect(3'b011, 16'h6010, "R5");
      wr(3'b011, 16'h0010);
      wr(3'b010, 16'h0020);
      set_pin(1, 1'b0);
      rd_expect(3'b011, 16'h6010, "R5");
      wr(3'b011, 16'h0010);

      // R6 bus wake gating
      cur_req = "R6";
      wr(3'b010, 16'h0000);
      pulse(3);
      rd_expect(3'b011, 16'h6000, "R6");
      wr(3'b010, 16'h0008);
      chk("R6", {15'h0, xcvr_lowpwr}, 16'h0001);
      reg_addr = 3'b011;
      pulse(3);
      rd_expect(3'b011, 16'h6008, "R6");
      wr(3'b011, 16'h0008);

      // R7 cyclic tick
      cur_req = "R7";
      pulse(2);
      rd_expect(3'b011, 16'h6080, "R7");
      wr(3'b011, 16'h0080);

      // R9 event against a clearing write
      cur_req = "R9";
      @(negedge clk); #2;
      reg_addr = 3'b011; reg_wdata = 16'h0080; reg_wr = 1'b1; cyc_tick = 1'b1;
      @(negedge clk); #2;
      reg_wr = 1'b0; reg_wdata = 16'h0; cyc_tick = 1'b0;
      rd_expect(3'b011, 16'h6080, "R9");

      // R3 lock on both words
      cur_req = "R3";
      wr(3'b010, 16'h1800);
      rd_expect(3'b010, 16'h5800, "R3");
      wr(3'b010, 16'h10C8);
      rd_expect(3'b010, 16'h5800, "R3");
      wr(3'b010, 16'h00C8);
      rd_expect(3'b010, 16'h4800, "R3");
      wr(3'b011, 16'h1000);
      rd_expect(3'b011, 16'h7080, "R3");
      wr(3'b011, 16'h1080);
      rd_expect(3'b011, 16'h7080, "R3");
      wr(3'b011, 16'h0000);
      wr(3'b011, 16'h0080);
      rd_expect(3'b011, 16'h6000, "R3");

      // R2 address tags and unmapped addresses
      cur_req = "R2";
      wr(3'b000, 16'hFFFF);
      rd_expect(3'b000, 16'h0000, "R2");
      rd_expect(3'b010, 16'h4800, "R2");
      wr(3'b010, 16'hE000);
      rd_expect(3'b010, 16'h4000, "R2");
      wr(3'b011, 16'hE000);
      rd_expect(3'b011, 16'h6000, "R2");
      wr(3'b111, 16'h1CF8);
      rd_expect(3'b111, 16'h0000, "R2");

      repeat (4) @(negedge clk);
      model_on = 1'b0;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule